// File: doc/BRIEF.md
# Load-Store Effective Address Generator

This block turns a load or store request into the byte address sent to memory and, where the request asks for it, a new value for the base register. It has a base register value, an offset source and an access size as inputs. The offset can be an implied unit step, a short unsigned constant, a long unsigned constant or the contents of an index register. The offset is scaled by the access size in bytes before it is added to or subtracted from the base.

Each request arriving with `req_valid` is registered. One cycle later the block presents the address, the writeback enable, the writeback value and an illegal-request flag. Only linear addressing is produced. The block does not model circular buffers, the register file or the memory access itself.

Top module: `lsea_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first request, `out_valid`, `wb_en` and `illegal` are 0 and `ea_addr` is 0.
- R2: A request sampled with `req_valid` high at a rising edge gives its results after that same edge. A rising edge with `req_valid` low leaves `out_valid`, `wb_en` and `illegal` at 0.
- R3: For variant 0 the address is base plus the scaled offset. For variant 1 the address is base minus the scaled offset. `wb_en` is 0 for both.
- R4: For variant 4 (post-add) and variant 5 (post-subtract) the address is the unmodified base. `wb_en` is 1 and `wb_val` is base plus (variant 4) or minus (variant 5) the scaled offset.
- R5: For variant 2 (pre-add) and variant 3 (pre-subtract) both `ea_addr` and `wb_val` equal base plus or minus the scaled offset, and `wb_en` is 1.
- R6: The offset is shifted left by `size`: code 0 is byte (x1), 1 is halfword (x2), 2 is word (x4) and 3 is doubleword (x8).
- R7: `form` selects the offset source:
  - 0: register indirect. The offset is 1 for the modifying variants and 0 for variants 0 and 1.
  - 1: the low 5 bits of `offset_val`, zero-extended, with the upper bits ignored.
  - 3: the whole of `offset_val`, taken as the index register.
- R8: `form` 2 uses the low 15 bits of `offset_val`, zero-extended. It is legal only with variant 0 and with `base_id` equal to 6'h2E or 6'h2F. In `base_id`, bit 5 set means the second register bank and bits 4:0 are the register number, so these two values are its registers 14 and 15. Any other use sets `illegal`, forces `wb_en` to 0 and presents the unmodified base on `ea_addr`.
- R9: Variant codes 6 and 7 set `illegal` with any form, force `wb_en` to 0 and present the unmodified base on `ea_addr`.
- R10: All additions and subtractions wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| form | input | 2 | Offset source select |
| variant | input | 3 | Modification variant |
| size | input | 2 | Access size code |
| base_id | input | 6 | Base register identity (bank bit and number) |
| base_val | input | 32 | Base register contents |
| offset_val | input | 32 | Constant field or index register contents |
| out_valid | output | 1 | Results valid |
| ea_addr | output | 32 | Effective byte address |
| wb_en | output | 1 | Base register writeback enable |
| wb_val | output | 32 | New base value |
| illegal | output | 1 | Request not permitted |

## Verification
The address and the base writeback are produced in the same cycle from the same scaled offset. In the post-modify variants they must differ, and in the pre-modify variants they must agree. The bench issues every variant on one base and offset and checks both outputs in the same sample, including cases where the modified base wraps past zero or past the top of the address space. It also places illegal requests next to legal ones, so that a writeback leaking through in the same cycle as the illegal flag is caught.

// File: rtl/lsea_gen.sv
module lsea_gen #(
  parameter int AW      = 32,
  parameter int SHORT_W = 5,
  parameter int LONG_W  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    form,
  input  logic [2:0]    variant,
  input  logic [1:0]    size,
  input  logic [5:0]    base_id,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] offset_val,
  output logic          out_valid,
  output logic [AW-1:0] ea_addr,
  output logic          wb_en,
  output logic [AW-1:0] wb_val,
  output logic          illegal
);

  logic [AW-1:0] raw_off, scaled, moved, addr_n;
  logic is_pre, is_post, is_mod, gp_base, bad;

  assign is_pre  = (variant == 3'd2) || (variant == 3'd3);
  assign is_post = (variant == 3'd4) || (variant == 3'd5);
  assign is_mod  = is_pre || is_post;
  assign gp_base = base_id[5] && (base_id[4:1] == 4'b0111);

  always_comb begin
    case (form)
      2'd0:    raw_off = is_mod ? AW'(1) : '0;
      2'd1:    raw_off = {{(AW-SHORT_W){1'b0}}, offset_val[SHORT_W-1:0]};
      2'd2:    raw_off = {{(AW-LONG_W){1'b0}}, offset_val[LONG_W-1:0]};
      default: raw_off = offset_val;
    endcase
  end

  assign scaled = raw_off << size;
  assign moved  = variant[0] ? base_val - scaled : base_val + scaled;
  assign bad    = (variant > 3'd5) ||
                  ((form == 2'd2) && (!gp_base || variant != 3'd0));
  assign addr_n = (bad || is_post) ? base_val : moved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea_addr   <= '0;
      wb_en     <= 1'b0;
      wb_val    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= req_valid;
      wb_en     <= req_valid && !bad && is_mod;
      illegal   <= req_valid && bad;
      if (req_valid) begin
        ea_addr <= addr_n;
        wb_val  <= moved;
      end
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wb_en && !illegal));

  p_nomod_no_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(variant) < 3'd2) |-> !wb_en);

  p_post_addr_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !illegal && ($past(variant) == 3'd4 || $past(variant) == 3'd5))
      |-> (ea_addr == $past(base_val) && wb_en));

  p_pre_addr_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !illegal && ($past(variant) == 3'd2 || $past(variant) == 3'd3))
      |-> (wb_en && ea_addr == wb_val));

  p_illegal_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wb_en && ea_addr == $past(base_val)));

  p_bad_variant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && $past(variant) > 3'd5) |-> illegal);

endmodule

// File: tb/tb_lsea_gen.sv
module tb_lsea_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  form = '0;
  logic [2:0]  variant = '0;
  logic [1:0]  size = '0;
  logic [5:0]  base_id = '0;
  logic [31:0] base_val = '0;
  logic [31:0] offset_val = '0;
  logic        out_valid, wb_en, illegal;
  logic [31:0] ea_addr, wb_val;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsea_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .form(form),
    .variant(variant), .size(size), .base_id(base_id), .base_val(base_val),
    .offset_val(offset_val), .out_valid(out_valid), .ea_addr(ea_addr),
    .wb_en(wb_en), .wb_val(wb_val), .illegal(illegal)
  );

  task automatic check(string req, logic [31:0] ea, logic wb, logic [31:0] wbv, logic ill);
    vectors++;
    if (out_valid !== 1'b1 || ea_addr !== ea || wb_en !== wb || illegal !== ill ||
        (wb && wb_val !== wbv)) begin
      miscompares++;
      $display("FAIL %s: got vld=%0b addr=%h wb=%0b wbv=%h ill=%0b exp addr=%h wb=%0b wbv=%h ill=%0b",
               req, out_valid, ea_addr, wb_en, wb_val, illegal, ea, wb, wbv, ill);
    end
  endtask

  task automatic issue(string req, logic [1:0] f, logic [2:0] v, logic [1:0] s,
                       logic [5:0] id, logic [31:0] b, logic [31:0] o,
                       logic [31:0] ea, logic wb, logic [31:0] wbv, logic ill);
    @(negedge clk);
    req_valid = 1'b1; form = f; variant = v; size = s;
    base_id = id; base_val = b; offset_val = o;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, ea, wb, wbv, ill);
  endtask

  task automatic t_reset;
    vectors++;
    if (out_valid !== 1'b0 || wb_en !== 1'b0 || illegal !== 1'b0 || ea_addr !== 32'h0) begin
      miscompares++;
      $display("FAIL R1: got vld=%0b wb=%0b ill=%0b addr=%h exp all zero",
               out_valid, wb_en, illegal, ea_addr);
    end
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || wb_en !== 1'b0 || illegal !== 1'b0) begin
      miscompares++;
      $display("FAIL R2: got vld=%0b wb=%0b ill=%0b exp 0 0 0", out_valid, wb_en, illegal);
    end
  endtask

  task automatic t_variants;
    issue("R3", 2'd1, 3'd0, 2'd2, 6'h04, 32'h1000, 32'd9, 32'h1024, 1'b0, 32'h0, 1'b0);
    issue("R3", 2'd1, 3'd1, 2'd2, 6'h04, 32'h1000, 32'd9, 32'h0FDC, 1'b0, 32'h0, 1'b0);
    issue("R5", 2'd1, 3'd2, 2'd2, 6'h04, 32'h1000, 32'd9, 32'h1024, 1'b1, 32'h1024, 1'b0);
    issue("R5", 2'd1, 3'd3, 2'd2, 6'h04, 32'h1000, 32'd9, 32'h0FDC, 1'b1, 32'h0FDC, 1'b0);
    issue("R4", 2'd1, 3'd4, 2'd2, 6'h04, 32'h1000, 32'd9, 32'h1000, 1'b1, 32'h1024, 1'b0);
    issue("R4", 2'd1, 3'd5, 2'd2, 6'h04, 32'h1000, 32'd9, 32'h1000, 1'b1, 32'h0FDC, 1'b0);
  endtask

  task automatic t_scale;
    issue("R6", 2'd3, 3'd0, 2'd0, 6'h05, 32'h100, 32'd3, 32'h103, 1'b0, 32'h0, 1'b0);
    issue("R6", 2'd3, 3'd0, 2'd1, 6'h05, 32'h100, 32'd3, 32'h106, 1'b0, 32'h0, 1'b0);
    issue("R6", 2'd3, 3'd0, 2'd2, 6'h05, 32'h100, 32'd3, 32'h10C, 1'b0, 32'h0, 1'b0);
    issue("R6", 2'd3, 3'd0, 2'd3, 6'h05, 32'h100, 32'd3, 32'h118, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_forms;
    issue("R7", 2'd0, 3'd2, 2'd1, 6'h06, 32'h200, 32'hFFFF, 32'h202, 1'b1, 32'h202, 1'b0);
    issue("R7", 2'd0, 3'd0, 2'd1, 6'h06, 32'h200, 32'hFFFF, 32'h200, 1'b0, 32'h0, 1'b0);
    issue("R7", 2'd1, 3'd0, 2'd0, 6'h06, 32'h10, 32'hFFFFFFE3, 32'h13, 1'b0, 32'h0, 1'b0);
    issue("R7", 2'd3, 3'd4, 2'd0, 6'h06, 32'h10, 32'h00012340, 32'h10, 1'b1, 32'h12350, 1'b0);
  endtask

  task automatic t_long;
    issue("R8", 2'd2, 3'd0, 2'd2, 6'h2E, 32'h4000, 32'hFFFF8001, 32'h4004, 1'b0, 32'h0, 1'b0);
    issue("R8", 2'd2, 3'd0, 2'd0, 6'h2F, 32'h0, 32'h00007FFF, 32'h7FFF, 1'b0, 32'h0, 1'b0);
    issue("R8", 2'd2, 3'd0, 2'd2, 6'h0E, 32'h4000, 32'h1, 32'h4000, 1'b0, 32'h0, 1'b1);
    issue("R8", 2'd2, 3'd2, 2'd2, 6'h2E, 32'h4000, 32'h1, 32'h4000, 1'b0, 32'h0, 1'b1);
    issue("R8", 2'd2, 3'd0, 2'd2, 6'h2D, 32'h4000, 32'h1, 32'h4000, 1'b0, 32'h0, 1'b1);
  endtask

  task automatic t_bad_variant;
    issue("R9", 2'd3, 3'd6, 2'd2, 6'h01, 32'h800, 32'h4, 32'h800, 1'b0, 32'h0, 1'b1);
    issue("R9", 2'd1, 3'd7, 2'd0, 6'h01, 32'h900, 32'h4, 32'h900, 1'b0, 32'h0, 1'b1);
    issue("R9", 2'd1, 3'd4, 2'd0, 6'h01, 32'h900, 32'h4, 32'h900, 1'b1, 32'h904, 1'b0);
  endtask

  task automatic t_wrap;
    issue("R10", 2'd3, 3'd2, 2'd2, 6'h02, 32'hFFFFFFFC, 32'd2, 32'h4, 1'b1, 32'h4, 1'b0);
    issue("R10", 2'd3, 3'd5, 2'd3, 6'h02, 32'h0, 32'd1, 32'h0, 1'b1, 32'hFFFFFFF8, 1'b0);
    issue("R10", 2'd3, 3'd1, 2'd0, 6'h02, 32'h1, 32'h3, 32'hFFFFFFFE, 1'b0, 32'h0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_variants();
    t_idle();
    t_scale();
    t_forms();
    t_long();
    t_bad_variant();
    t_wrap();
    t_idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule